// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave Controller

This block is the control side of a small three-wire serial memory slave. A host selects it with a chip-select line and clocks instructions in on a data line. Each instruction begins with a start bit, then a two-bit operation code, an address and, for writes, a data field. The block serves reads from an internal register array. It performs writes and erases as a self-timed program cycle that is measured in system-clock cycles. While that cycle runs, the single data-out line can carry a ready/busy flag.

The three serial inputs are sampled by the system clock through a two-flop synchronizer, and the block acts on the rising edges of the serial clock. An organization input chooses between word access and byte access over the same storage. In word mode there are 16-bit words with 10 address bits. In byte mode there are 8-bit bytes with 11 address bits. Word `w` covers byte `2w` as its upper half and byte `2w+1` as its lower half.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is low, the instruction decoder stays idle and `do_oe` is 0.
- R2: While the block is selected and waiting for a start bit, serial clock edges with data in at 0 have no effect. The first rising edge with data in at 1 is the start bit.
- R3: The bits that follow the start bit arrive most significant bit first. They are two operation bits (10 read, 01 write, 11 erase, 00 extended) and then the address. For a read, the block drives 0 on the edge of the last address bit, then one data bit per rising edge, most significant bit first.
- R4: A write or erase changes storage only if an enable instruction (extended, top two address bits 11) has been given since reset. No disable instruction (extended, top two address bits 00) may have come after it. An erase sets every bit of the location to 1.
- R5: An extended instruction with top address bits 01 followed by a data field writes that data to every location. Top address bits 10 set every bit of the array to 1. Both also require the enable.
- R6: A program cycle keeps the flag busy for exactly `WR_CYCLES` system clocks. The flag rises one clock after the last data bit is taken, and that bit is taken three clocks after its serial clock edge is driven. If chip select goes low and then high while the flag is busy, `do_o` shows 0 while busy and 1 once ready.
- R7: If chip select stays low for the entire program cycle, `do_oe` stays 0 after the block is selected again.
- R8: Once status is shown, it remains visible across deselects until a start bit is received and chip select is then taken low.
- R9: A program cycle that has started completes and updates storage even if chip select falls during it.
- R10: After an instruction's last bit, further serial clock edges in the same selection are ignored until chip select goes low.
- R11: With `org` at 1, accesses are 16-bit words with 10 address bits. With `org` at 0, accesses are 8-bit bytes with 11 address bits. Word `w` is bytes `2w` (upper half) and `2w+1` (lower half).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, high selects |
| sclk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| org | input | 1 | 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data out / ready-busy flag |
| do_oe | output | 1 | Output enable for the data-out driver |

## Verification
The bench measures the busy window down to the exact system clock, from the last serial edge to the ready level. A timer that is off by one cycle, or a start that is delayed by an extra register, moves that edge and is caught. It checks that status stays hidden when chip select is held low through the whole cycle, and that a status flag survives a plain deselect but is cleared by a start bit followed by a deselect. A design that mixed up these two conditions would show or hide the flag at the wrong times. It writes bytes and reads them back as words to catch wrong byte order or wrong address width, and it sends a full write pattern after a finished read to prove that trailing edges do not start a second instruction. Writes under disable, the dummy zero before read data, and leading zero-valued clocks before a start bit are each exercised.

// File: rtl/mw_pkg.sv
// Package: shared state, operation and array-command encodings for the
// three-wire serial memory slave.
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_RDOUT, ST_DONE
    } mw_state_e;

    typedef enum logic [1:0] {
        CMD_NONE, CMD_ONE, CMD_ALL
    } mw_cmd_e;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_DIS  = 2'b00;
    localparam logic [1:0] EXT_WALL = 2'b01;
    localparam logic [1:0] EXT_EALL = 2'b10;
    localparam logic [1:0] EXT_EN   = 2'b11;
endpackage

// File: rtl/mw_sync.sv
// Module: mw_sync
// Brings cs, sclk and di into the system clock domain through a STAGES-deep
// flop chain. Produces the synchronized levels and one-cycle edge pulses.
// Assumes each serial level is held for at least two system clocks.
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sclk_rise,
    output logic cs_rise,
    output logic cs_fall
);
    logic [STAGES-1:0][2:0] pipe_q;
    logic                   sclk_prev_q;
    logic                   cs_prev_q;

    // Shift the three raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], {cs, sclk, di}};
    end

    // Remember the last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            cs_prev_q   <= 1'b0;
        end else begin
            sclk_prev_q <= pipe_q[STAGES-1][1];
            cs_prev_q   <= pipe_q[STAGES-1][2];
        end
    end

    assign cs_s      = pipe_q[STAGES-1][2];
    assign di_s      = pipe_q[STAGES-1][0];
    assign sclk_rise = pipe_q[STAGES-1][1] & ~sclk_prev_q;
    assign cs_rise   = cs_s & ~cs_prev_q;
    assign cs_fall   = ~cs_s & cs_prev_q;
endmodule

// File: rtl/mw_timer.sv
// Module: mw_timer
// Self-timed program cycle: busy for exactly CYCLES system clocks after a
// start pulse. Needs no serial clock. Assumes no start while busy.
module mw_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (start_i)     cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // R6: a new cycle is never launched on top of a running one.
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    // R9: once running with more than one cycle left, it is still busy next clock.
    a_r9_runs_to_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q > 1) |=> busy_o);
endmodule

// File: rtl/mw_array.sv
// Module: mw_array
// Byte-organized storage seen as bytes (org=0) or 16-bit words (org=1).
// Word w = {byte 2w, byte 2w+1}. Read is combinational, and a command
// writes one location or the whole array in one clock. No reset, because
// the contents model nonvolatile cells.
module mw_array #(
    parameter int BYTES = 2048
) (
    input  logic                     clk,
    input  mw_pkg::mw_cmd_e          cmd_i,
    input  logic                     org_i,
    input  logic [$clog2(BYTES)-1:0] addr_i,
    input  logic [15:0]              wdata_i,
    output logic [15:0]              rdata_o
);
    import mw_pkg::*;
    localparam int AWB = $clog2(BYTES);

    logic [7:0]     mem [BYTES];
    logic [AWB-1:0] hi_idx;
    logic [AWB-1:0] lo_idx;

    assign hi_idx = org_i ? {addr_i[AWB-2:0], 1'b0} : addr_i;
    assign lo_idx = {addr_i[AWB-2:0], 1'b1};

    // Apply a single-location or whole-array update.
    always_ff @(posedge clk) begin
        if (cmd_i == CMD_ONE) begin
            if (org_i) begin
                mem[hi_idx] <= wdata_i[15:8];
                mem[lo_idx] <= wdata_i[7:0];
            end else begin
                mem[hi_idx] <= wdata_i[7:0];
            end
        end else if (cmd_i == CMD_ALL) begin
            for (int i = 0; i < BYTES; i++)
                mem[i] <= (!org_i) ? wdata_i[7:0] :
                          (i % 2 == 0) ? wdata_i[15:8] : wdata_i[7:0];
        end
    end

    assign rdata_o = org_i ? {mem[hi_idx], mem[lo_idx]} : {8'h00, mem[hi_idx]};
endmodule

// File: rtl/mw_eeprom.sv
// Module: mw_eeprom (top)
// Instruction decoder for the three-wire serial memory slave. It waits for a
// start bit, shifts in the operation, address and data, serves reads, and
// launches self-timed program cycles. It drives the ready/busy flag on data
// out. Assumes org is static during an instruction.
module mw_eeprom #(
    parameter int BYTES     = 2048,
    parameter int WR_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic di,
    input  logic org,
    output logic do_o,
    output logic do_oe
);
    import mw_pkg::*;
    localparam int AWB = $clog2(BYTES);
    localparam int CW  = 5;

    logic cs_s, di_s, sclk_rise, cs_rise, cs_fall, busy;
    mw_state_e      state_q;
    logic [CW-1:0]  cnt_q;
    logic [1:0]     op_q;
    logic [AWB-1:0] a_sr_q, a_next, cmd_addr_q, arr_addr;
    logic [15:0]    d_sr_q, d_next, rd_sr_q, cmd_data_q, rdata;
    logic           do_q, wen_q, stat_en_q, start_seen_q;
    mw_cmd_e        cmd_q;
    logic [CW-1:0]  aw_m1, dw_m1, dw_full;
    logic [1:0]     ext;
    logic           rd_on;

    mw_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di),
        .cs_s(cs_s), .di_s(di_s), .sclk_rise(sclk_rise),
        .cs_rise(cs_rise), .cs_fall(cs_fall)
    );

    mw_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(cmd_q != CMD_NONE), .busy_o(busy)
    );

    mw_array #(.BYTES(BYTES)) u_array (
        .clk(clk), .cmd_i(cmd_q), .org_i(org), .addr_i(arr_addr),
        .wdata_i(cmd_data_q), .rdata_o(rdata)
    );

    assign aw_m1    = org ? CW'(AWB - 2) : CW'(AWB - 1);
    assign dw_m1    = org ? CW'(15) : CW'(7);
    assign dw_full  = dw_m1 + 1'b1;
    assign a_next   = {a_sr_q[AWB-2:0], di_s};
    assign d_next   = {d_sr_q[14:0], di_s};
    assign ext      = org ? a_next[AWB-2 -: 2] : a_next[AWB-1 -: 2];
    assign arr_addr = (cmd_q != CMD_NONE) ? cmd_addr_q : a_next;
    assign rd_on    = (state_q == ST_RDOUT);

    // Serial instruction decoder, status visibility and write-enable latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            op_q         <= '0;
            a_sr_q       <= '0;
            d_sr_q       <= '0;
            rd_sr_q      <= '0;
            do_q         <= 1'b0;
            wen_q        <= 1'b0;
            stat_en_q    <= 1'b0;
            start_seen_q <= 1'b0;
            cmd_q        <= CMD_NONE;
            cmd_addr_q   <= '0;
            cmd_data_q   <= '0;
        end else begin
            cmd_q <= CMD_NONE;
            if (cs_fall && start_seen_q) stat_en_q <= 1'b0;
            if (cs_fall)                 start_seen_q <= 1'b0;
            if (cs_rise && busy)         stat_en_q <= 1'b1;
            if (!cs_s) begin
                state_q <= ST_IDLE;
            end else if (sclk_rise) begin
                unique case (state_q)
                    ST_IDLE: if (di_s && !busy) begin
                        state_q      <= ST_OPC;
                        cnt_q        <= '0;
                        start_seen_q <= 1'b1;
                    end
                    ST_OPC: begin
                        op_q  <= {op_q[0], di_s};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(1)) begin
                            state_q <= ST_ADDR;
                            cnt_q   <= '0;
                            a_sr_q  <= '0;
                        end
                    end
                    ST_ADDR: begin
                        a_sr_q <= a_next;
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == aw_m1) begin
                            cnt_q      <= '0;
                            d_sr_q     <= '0;
                            state_q    <= ST_DONE;
                            cmd_addr_q <= a_next;
                            cmd_data_q <= 16'hFFFF;
                            unique case (op_q)
                                OP_READ: begin
                                    rd_sr_q <= org ? rdata : {rdata[7:0], 8'h00};
                                    do_q    <= 1'b0;
                                    state_q <= ST_RDOUT;
                                end
                                OP_WRITE: state_q <= ST_DATA;
                                OP_ERASE: if (wen_q) cmd_q <= CMD_ONE;
                                default: unique case (ext)
                                    EXT_EN:   wen_q <= 1'b1;
                                    EXT_DIS:  wen_q <= 1'b0;
                                    EXT_WALL: state_q <= ST_DATA;
                                    default:  if (wen_q) cmd_q <= CMD_ALL;
                                endcase
                            endcase
                        end
                    end
                    ST_DATA: begin
                        d_sr_q <= d_next;
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == dw_m1) begin
                            state_q    <= ST_DONE;
                            cmd_addr_q <= a_sr_q;
                            cmd_data_q <= org ? d_next : {8'h00, d_next[7:0]};
                            if (wen_q) cmd_q <= (op_q == OP_EXT) ? CMD_ALL : CMD_ONE;
                        end
                    end
                    ST_RDOUT: begin
                        if (cnt_q == dw_full) begin
                            state_q <= ST_DONE;
                        end else begin
                            do_q    <= rd_sr_q[15];
                            rd_sr_q <= {rd_sr_q[14:0], 1'b0};
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign do_oe = cs_s & (rd_on | stat_en_q);
    assign do_o  = rd_on ? do_q : ~busy;

    // R1: deselect forces the decoder idle on the next clock.
    a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> state_q == ST_IDLE);
    // R1: the output driver is never enabled while deselected.
    a_r1_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        do_oe |-> cs_s);
    // R3: read output opens with the dummy zero bit.
    a_r3_dummy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && $past(state_q) != ST_RDOUT) |-> !do_q);
    // R4: no storage command is issued without the write enable.
    a_r4_locked_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != CMD_NONE) |-> wen_q);
endmodule

// File: tb/tb_mw_eeprom.sv
// Directed bench for mw_eeprom: one task for each scenario, each checking its own results.
module tb_mw_eeprom;
    localparam int WR = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b1;
    logic do_o, do_oe;
    int   n_tests = 0, n_fail = 0;

    always #10 clk = ~clk;

    mw_eeprom #(.BYTES(2048), .WR_CYCLES(WR)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di), .org(org),
        .do_o(do_o), .do_oe(do_oe)
    );

    function automatic int aw(); return org ? 10 : 11; endfunction
    function automatic int dw(); return org ? 16 : 8; endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n); repeat (n) @(negedge clk); endtask

    task automatic pulse(bit b);
        @(negedge clk) di = b;
        tick(3); sclk = 1'b1; tick(4); sclk = 1'b0; tick(3);
    endtask

    task automatic send(int val, int n);
        for (int i = n - 1; i >= 0; i--) pulse(val[i]);
    endtask

    task automatic sel();   @(negedge clk) cs = 1'b1; tick(4); endtask
    task automatic desel(); @(negedge clk) cs = 1'b0; tick(4); endtask

    task automatic instr(int op, int addr);
        sel(); pulse(1'b1); send(op, 2); send(addr, aw());
    endtask

    task automatic ext_cmd(int code);
        instr(0, code << (aw() - 2)); desel();
    endtask

    task automatic write_loc(int addr, int data);
        instr(1, addr); send(data, dw()); desel(); tick(WR + 10);
    endtask

    task automatic read_chk(string req, int addr, int exp);
        int v = 0;
        instr(2, addr);
        chk({req, " dummy bit"}, {do_oe, do_o}, 2'b10);
        for (int i = 0; i < dw(); i++) begin
            pulse(1'b0);
            v = (v << 1) | int'(do_o);
        end
        chk({req, " read data"}, v, exp);
        desel();
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", do_oe, 0);
        sel();
        chk("R1 oe selected no start", do_oe, 0);
        desel();
    endtask

    task automatic t_lock();
        org = 1'b1;
        ext_cmd(3);                      // enable
        write_loc(3, 16'hAAAA);
        ext_cmd(0);                      // disable
        write_loc(3, 16'h1234);
        read_chk("R4 write while disabled", 3, 16'hAAAA);
    endtask

    task automatic t_word_rw();
        ext_cmd(3);
        write_loc(7, 16'hC35A);
        read_chk("R3 word read", 7, 16'hC35A);
        instr(3, 7); desel(); tick(WR + 10);
        read_chk("R4 erase to ones", 7, 16'hFFFF);
    endtask

    task automatic t_byte_org();
        org = 1'b0;
        write_loc(8, 8'h81);
        write_loc(9, 8'h3C);
        read_chk("R11 byte read", 9, 8'h3C);
        org = 1'b1;
        read_chk("R11 word view of bytes", 4, 16'h813C);
    endtask

    task automatic t_start_wait();
        int v = 0;
        sel();
        for (int i = 0; i < 5; i++) pulse(1'b0);
        chk("R2 oe during zero clocks", do_oe, 0);
        pulse(1'b1); send(2, 2); send(4, 10);
        for (int i = 0; i < 16; i++) begin
            pulse(1'b0);
            v = (v << 1) | int'(do_o);
        end
        chk("R2 read after leading zeros", v, 16'h813C);
        desel();
    endtask

    task automatic t_trailing();
        int v = 0;
        instr(2, 4);
        for (int i = 0; i < 16; i++) pulse(1'b0);
        pulse(1'b0);
        chk("R10 oe after read end", do_oe, 0);
        pulse(1'b1); send(1, 2); send(4, 10); send(16'h0000, 16);
        chk("R10 oe after trailing bits", do_oe, 0);
        desel(); tick(WR + 10); sel();
        chk("R10 no status from trailing write", do_oe, 0);
        desel();
        read_chk("R10 storage unchanged", 4, 16'h813C);
    endtask

    task automatic t_busy();
        bit seen_busy = 1'b0;
        instr(1, 12);
        send(16'h0F0F >> 1, 15);
        @(negedge clk) begin di = 1'b1; sclk = 1'b1; end
        for (int t = 1; t <= WR + 4; t++) begin
            @(negedge clk);
            if (t == 1) begin sclk = 1'b0; cs = 1'b0; end
            if (t == 2) cs = 1'b1;
            if (t == 8) seen_busy = do_oe && !do_o;
            if (t == WR + 3) chk("R6 busy in last cycle", {do_oe, do_o}, 2'b10);
            if (t == WR + 4) chk("R6 ready after WR cycles", {do_oe, do_o}, 2'b11);
        end
        chk("R6 busy visible after cs toggle", seen_busy, 1);
        desel(); sel();
        chk("R8 status kept over plain deselect", {do_oe, do_o}, 2'b11);
        pulse(1'b1); desel(); sel();
        chk("R8 status cleared by start then deselect", do_oe, 0);
        desel();
        read_chk("R9 write completed across deselect", 12, 16'h0F0F);
    endtask

    task automatic t_hidden();
        instr(1, 20); send(16'h1357, 16);
        @(negedge clk) cs = 1'b0;
        tick(WR + 10);
        sel();
        chk("R7 status hidden when cs held low", do_oe, 0);
        tick(5);
        chk("R7 still hidden", do_oe, 0);
        desel();
        read_chk("R9 write completed with cs low", 20, 16'h1357);
    endtask

    task automatic t_all();
        org = 1'b0;
        instr(0, 1 << 9); send(8'h5A, 8); desel(); tick(WR + 10);
        read_chk("R5 write all first", 0, 8'h5A);
        read_chk("R5 write all last", 2047, 8'h5A);
        instr(0, 2 << 9); desel(); tick(WR + 10);
        org = 1'b1;
        read_chk("R5 erase all", 1023, 16'hFFFF);
        read_chk("R5 erase all low word", 0, 16'hFFFF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_lock();
        t_word_rw();
        t_byte_org();
        t_start_wait();
        t_trailing();
        t_busy();
        t_hidden();
        t_all();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule